// File: doc/BRIEF.md
# Ethernet Receive Deframer with Pad Removal

This block sits between a media-independent 4-bit receive path and the receive buffer of a network controller. While the data-valid input is high it looks for the start-of-frame delimiter, throws away everything before it, and packs the following nibbles into bytes, low nibble first. Each byte goes through a CRC-32 check, and the deframer decides from the length/type field whether padding and the trailing check sequence are passed on or removed.

Short frames, meaning fewer than 64 bytes after the delimiter, are normally deleted in full. To make this possible, delivered bytes wait in a small circular staging buffer until the frame has proven long enough. A per-frame configuration latched at the delimiter allows runt frames to be accepted for diagnostics. Pad removal can be switched off on its own.

Output is a byte stream with valid and last markers, and it cannot be stalled. A separate one-cycle end-of-frame status carries an FCS-error flag and an alignment-error flag. Consecutive frames must be separated by enough idle time for the staging buffer to drain, which is at most 64 cycles of backlog.

Top module: `eth_rx_deframer`

## Requirements
- R1: After data-valid rises, nibbles are discarded until a nibble 0x5 is directly followed by a nibble 0xD. A lone 0xD or other stray nibbles do not start a frame.
- R2: Once the delimiter is found, every pair of nibbles forms one byte. The first nibble of the pair is bits 3:0 and the second is bits 7:4.
- R3: When pad removal is enabled and the length/type field (byte 12 is the high byte, byte 13 the low byte, counted from 0 after the delimiter) is below 46, only bytes with index below 14 plus the length value are delivered. Pad and FCS bytes after that point are dropped.
- R4: When pad removal is disabled, or the length field is 46 or more, every received byte including the 4 FCS bytes is delivered unchanged.
- R5: With runt acceptance off, a frame of fewer than 64 complete bytes produces no output bytes and no end-of-frame status. A frame of exactly 64 bytes is kept.
- R6: With runt acceptance on, a short frame is delivered and reported like any other frame.
- R7: eof_fcs_err is 1 exactly when the CRC-32 over all complete bytes, FCS included, does not leave the residue 0xC704DD7B. This check also runs when the FCS bytes are withheld. Both error flags are 0 whenever eof_valid is 0.
- R8: If data-valid falls after an odd number of nibbles following the delimiter, the trailing nibble is dropped and eof_align_err is 1.
- R9: out_last is high on the final delivered byte of a kept frame and on no other byte.
- R10: For a kept frame, eof_valid is high for exactly one cycle. That cycle is the second clock edge after the first edge that samples data-valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_nib | input | 4 | Receive nibble |
| strip_en | input | 1 | Enable pad and FCS removal (latched at the delimiter) |
| runt_accept | input | 1 | Keep frames shorter than 64 bytes (latched at the delimiter) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final delivered byte of the frame |
| eof_valid | output | 1 | End-of-frame status strobe |
| eof_fcs_err | output | 1 | CRC residue mismatch |
| eof_align_err | output | 1 | Frame ended on a half byte |

## Verification
A wrong delimiter hunt or nibble order corrupts the first byte at the output, and the CRC flag also fails for that frame. A wrong byte counter or length capture shows up as a delivered-byte count that differs from 14 plus the length, or as a runt that escapes deletion. Both appear as soon as the staging buffer drains at the end of the frame. Staging-pointer mistakes are seen as a missing or misplaced last marker, or as bytes left over from a deleted frame leaking into the next frame's stream. The sweep crosses both configuration inputs with length values and frame sizes on each side of the 46 and 64 boundaries.

// File: rtl/eth_rx_pkg.sv
// Shared constants, state type and CRC helpers for the receive deframer.
package eth_rx_pkg;
    localparam logic [3:0]  PRE_NIB       = 4'h5;
    localparam logic [3:0]  SFD_HI_NIB    = 4'hD;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE   = 32'hC704DD7B;

    typedef enum logic {ST_HUNT, ST_DATA} rx_state_e;

    // Advance a reflected CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc_next_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Reverse bit order of a 32-bit word.
    function automatic logic [31:0] bit_rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction
endpackage

// File: rtl/rx_nibble_align.sv
// Hunts for the start delimiter in the nibble stream and assembles bytes.
// Assumes one nibble per clock while rx_dv is high; low nibble arrives first.
// Emits registered one-cycle pulses: sof at the delimiter, byte_stb per byte,
// fr_end when rx_dv falls inside a frame (fr_align set on a half byte).
module rx_nibble_align
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic [3:0] rx_nib,
    output logic       sof,
    output logic       byte_stb,
    output logic [7:0] byte_data,
    output logic       fr_end,
    output logic       fr_align
);
    rx_state_e  state;
    logic [3:0] prev_nib;
    logic [3:0] lo_nib;
    logic       half;

    // Delimiter search, byte packing and end-of-frame detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            prev_nib  <= 4'h0;
            lo_nib    <= 4'h0;
            half      <= 1'b0;
            sof       <= 1'b0;
            byte_stb  <= 1'b0;
            byte_data <= 8'h00;
            fr_end    <= 1'b0;
            fr_align  <= 1'b0;
        end else begin
            sof      <= 1'b0;
            byte_stb <= 1'b0;
            fr_end   <= 1'b0;
            if (!rx_dv) begin
                prev_nib <= 4'h0;
                if (state == ST_DATA) begin
                    fr_end   <= 1'b1;
                    fr_align <= half;
                end
                state <= ST_HUNT;
                half  <= 1'b0;
            end else begin
                case (state)
                    ST_HUNT: begin
                        prev_nib <= rx_nib;
                        if (prev_nib == PRE_NIB && rx_nib == SFD_HI_NIB) begin
                            state <= ST_DATA;
                            sof   <= 1'b1;
                            half  <= 1'b0;
                        end
                    end
                    default: begin
                        if (!half) begin
                            lo_nib <= rx_nib;
                            half   <= 1'b1;
                        end else begin
                            byte_data <= {rx_nib, lo_nib};
                            byte_stb  <= 1'b1;
                            half      <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_crc_check.sv
// Running CRC-32 over every assembled byte of a frame, FCS included.
// Assumes byte_stb never coincides with sof. crc_ok is valid once the
// last byte strobe has been absorbed.
module rx_crc_check
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof,
    input  logic       byte_stb,
    input  logic [7:0] byte_data,
    output logic       crc_ok
);
    logic [31:0] crc_q;

    // Seed at the delimiter, advance per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        crc_q <= '1;
        else if (sof)      crc_q <= '1;
        else if (byte_stb) crc_q <= crc_next_byte(crc_q, byte_data);
    end

    // Compare residue against the fixed good-frame constant.
    always_comb crc_ok = (bit_rev32(crc_q) == CRC_RESIDUE);
endmodule

// File: rtl/rx_stage_buf.sv
// Circular staging buffer. Bytes of the open frame are released only up to
// a limit pointer; the newest byte is always held back until the frame end
// so it can carry the last marker. A dropped frame rewinds the write pointer.
// Assumes DEPTH is a power of two and the inter-frame gap lets it drain.
module rx_stage_buf #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_sof,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       hold_open,
    input  logic       end_keep,
    input  logic       end_drop,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    logic [7:0]    mem [DEPTH];
    logic [DEPTH-1:0] last_m;
    logic [AW-1:0] wr_p, rd_p, lim_p, fst_p;
    logic [AW-1:0] wr_prev;

    always_comb wr_prev = wr_p - AW'(1);

    // Byte storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_p] <= wr_data;
    end

    // Pointer, release-limit and last-marker maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p   <= '0;
            rd_p   <= '0;
            lim_p  <= '0;
            fst_p  <= '0;
            last_m <= '0;
        end else begin
            if (frm_sof) fst_p <= wr_p;
            if (wr_en) begin
                last_m[wr_p] <= 1'b0;
                wr_p         <= wr_p + AW'(1);
            end
            if (end_drop) wr_p <= fst_p;
            if (end_keep) begin
                lim_p <= wr_p;
                if (wr_p != fst_p) last_m[wr_prev] <= 1'b1;
            end else if (hold_open && wr_p != fst_p) begin
                lim_p <= wr_prev;
            end
            if (out_valid) rd_p <= rd_p + AW'(1);
        end
    end

    // Head-of-buffer outputs.
    always_comb begin
        out_valid = (rd_p != lim_p);
        out_data  = mem[rd_p];
        out_last  = out_valid && last_m[rd_p];
    end
endmodule

// File: rtl/eth_rx_deframer.sv
// Receive deframer top: delimiter hunt, byte assembly, CRC check, length-based
// pad removal and runt deletion in front of a staging buffer.
// Assumes configuration inputs are sampled at the delimiter and the output
// side always accepts one byte per cycle.
module eth_rx_deframer #(
    parameter int MIN_FRAME   = 64,
    parameter int HDR_BYTES   = 14,
    parameter int MIN_PAYLOAD = 46,
    parameter int STAGE_DEPTH = 128,
    parameter int CNT_W       = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic [3:0] rx_nib,
    input  logic       strip_en,
    input  logic       runt_accept,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       eof_valid,
    output logic       eof_fcs_err,
    output logic       eof_align_err
);
    localparam logic [CNT_W-1:0] LEN_HI_IDX = CNT_W'(HDR_BYTES - 2);
    localparam logic [CNT_W-1:0] LEN_LO_IDX = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] COMMIT_IDX = CNT_W'(MIN_FRAME - 1);

    logic       sof, byte_stb, fr_end, fr_align, crc_ok;
    logic [7:0] byte_data;

    logic [CNT_W-1:0] cnt;
    logic [7:0]       len_hi;
    logic [15:0]      len_val;
    logic             len_ok, strip_cfg, committed;
    logic             strip_act, deliver, wr_en, end_keep, end_drop;

    rx_nibble_align u_align (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib),
        .sof(sof), .byte_stb(byte_stb), .byte_data(byte_data),
        .fr_end(fr_end), .fr_align(fr_align)
    );

    rx_crc_check u_crc (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_stb(byte_stb),
        .byte_data(byte_data), .crc_ok(crc_ok)
    );

    // Pad-removal decision and delivery gating for the current byte.
    always_comb begin
        strip_act = strip_cfg && len_ok && (len_val < 16'(MIN_PAYLOAD));
        deliver   = !strip_act || (32'(cnt) < 32'(HDR_BYTES) + 32'(len_val));
        wr_en     = byte_stb && deliver;
        end_keep  = fr_end && committed;
        end_drop  = fr_end && !committed;
    end

    // Per-frame byte counting, length capture and commit tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            len_hi    <= 8'h00;
            len_val   <= 16'h0000;
            len_ok    <= 1'b0;
            strip_cfg <= 1'b0;
            committed <= 1'b0;
        end else if (sof) begin
            cnt       <= '0;
            len_ok    <= 1'b0;
            strip_cfg <= strip_en;
            committed <= runt_accept;
        end else begin
            if (byte_stb) begin
                if (cnt != '1) cnt <= cnt + CNT_W'(1);
                if (cnt == LEN_HI_IDX) len_hi <= byte_data;
                if (cnt == LEN_LO_IDX) begin
                    len_val <= {len_hi, byte_data};
                    len_ok  <= 1'b1;
                end
                if (cnt == COMMIT_IDX) committed <= 1'b1;
            end
            if (fr_end) committed <= 1'b0;
        end
    end

    // End-of-frame status for kept frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eof_valid     <= 1'b0;
            eof_fcs_err   <= 1'b0;
            eof_align_err <= 1'b0;
        end else begin
            eof_valid     <= end_keep;
            eof_fcs_err   <= end_keep && !crc_ok;
            eof_align_err <= end_keep && fr_align;
        end
    end

    rx_stage_buf #(.DEPTH(STAGE_DEPTH)) u_stage (
        .clk(clk), .rst_n(rst_n), .frm_sof(sof), .wr_en(wr_en),
        .wr_data(byte_data), .hold_open(committed), .end_keep(end_keep),
        .end_drop(end_drop), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );
endmodule

// File: rtl/eth_rx_deframer_chk.sv
// Port-level protocol checks for the deframer, attached by bind.
module eth_rx_deframer_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_dv,
    input logic out_valid,
    input logic out_last,
    input logic eof_valid,
    input logic eof_fcs_err,
    input logic eof_align_err
);
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R9
    AST_EOF_AFTER_DV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid |-> ($past(rx_dv, 2) == 1'b0)); // R10
    AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid |=> !eof_valid); // R10
    AST_FLAGS_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_fcs_err || eof_align_err) |-> eof_valid); // R7
endmodule

bind eth_rx_deframer eth_rx_deframer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .out_valid(out_valid),
    .out_last(out_last), .eof_valid(eof_valid), .eof_fcs_err(eof_fcs_err),
    .eof_align_err(eof_align_err)
);

// File: tb/eth_rx_deframer_test.sv
module eth_rx_deframer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_dv = 1'b0;
    logic [3:0] rx_nib = 4'h0;
    logic       strip_en = 1'b0;
    logic       runt_accept = 1'b0;
    logic       out_valid, out_last, eof_valid, eof_fcs_err, eof_align_err;
    logic [7:0] out_data;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    logic [7:0] got[$];
    int last_cnt, last_idx, eof_cnt, eof_cyc, drop_cyc;
    bit eof_fcs, eof_al;

    eth_rx_deframer uut (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib),
        .strip_en(strip_en), .runt_accept(runt_accept), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .eof_valid(eof_valid),
        .eof_fcs_err(eof_fcs_err), .eof_align_err(eof_align_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    // Collect outputs away from the active edge.
    always @(negedge clk) begin
        if (out_valid) begin
            got.push_back(out_data);
            if (out_last) begin last_cnt++; last_idx = got.size() - 1; end
        end
        if (eof_valid) begin
            eof_cnt++; eof_fcs = eof_fcs_err; eof_al = eof_align_err; eof_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_of(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (q[k]) begin
            c ^= {24'h0, q[k]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    task automatic send_nib(input logic [3:0] n);
        @(negedge clk); rx_dv = 1'b1; rx_nib = n;
    endtask

    task automatic run_frame(input int len, input int ndata, input bit strip, input bit racc,
                             input bit corrupt, input bit odd, input bit junk);
        logic [7:0] q[$];
        logic [31:0] fcs;
        int tot, exp_n, mism;
        bit kept;
        for (int i = 0; i < ndata; i++) begin
            if (i < 12)       q.push_back(8'(i * 7 + 3 + len));
            else if (i == 12) q.push_back(8'(len >> 8));
            else if (i == 13) q.push_back(8'(len));
            else              q.push_back(8'(i * 13 + len));
        end
        fcs = ~crc_of(q);
        for (int k = 0; k < 4; k++) q.push_back(fcs[8*k +: 8]);
        if (corrupt) q[ndata / 2] ^= 8'h40;
        tot  = q.size();
        kept = (tot >= 64) || racc;
        exp_n = 0;
        if (kept) begin
            if (strip && tot >= 14 && len < 46) exp_n = (tot < 14 + len) ? tot : 14 + len;
            else exp_n = tot;
        end
        got.delete(); last_cnt = 0; last_idx = -1; eof_cnt = 0; eof_cyc = -1;
        @(negedge clk); strip_en = strip; runt_accept = racc;
        if (junk) begin send_nib(4'hD); send_nib(4'h3); send_nib(4'hD); end
        for (int p = 0; p < 15; p++) send_nib(4'h5);
        send_nib(4'hD);
        foreach (q[k]) begin send_nib(q[k][3:0]); send_nib(q[k][7:4]); end
        if (odd) send_nib(4'hA);
        @(negedge clk); rx_dv = 1'b0; rx_nib = 4'h0; drop_cyc = cyc;
        repeat (250) @(negedge clk);
        // R5 R6: keep or delete decision, R3 R4: delivered count
        chk(eof_cnt == (kept ? 1 : 0), kept ? "R6" : "R5", "eof count", eof_cnt, kept ? 1 : 0);
        chk(got.size() == exp_n, (strip && len < 46) ? "R3" : "R4", "delivered bytes", got.size(), exp_n);
        // R1 R2: content of delivered bytes
        mism = 0;
        for (int k = 0; k < got.size() && k < exp_n; k++) if (got[k] != q[k]) mism++;
        chk(mism == 0, "R2", "mismatched bytes", mism, 0);
        if (kept) begin
            chk(last_cnt == 1 && last_idx == exp_n - 1, "R9", "last marker index", last_idx, exp_n - 1);
            chk(eof_fcs == corrupt, "R7", "fcs flag", eof_fcs, corrupt);
            chk(eof_al == odd, "R8", "align flag", eof_al, odd);
            chk(eof_cyc == drop_cyc + 2, "R10", "eof cycle offset", eof_cyc - drop_cyc, 2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lens[11]  = '{0, 5, 30, 45, 46, 47, 100, 10, 40, 45, 46};
        int sizes[11] = '{60, 60, 60, 60, 60, 61, 114, 24, 50, 59, 60};
        repeat (4) @(negedge clk);
        chk(!out_valid && !eof_valid, "R10", "outputs in reset", {out_valid, eof_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !eof_valid, "R9", "outputs after reset", {out_valid, eof_valid}, 0);
        for (int cfg = 0; cfg < 4; cfg++)
            for (int f = 0; f < 11; f++)
                run_frame(lens[f], sizes[f], cfg[0], cfg[1], 1'b0, 1'b0, 1'b0);
        run_frame(20, 60, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R7 error with FCS withheld
        run_frame(80, 94, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R7
        run_frame(50, 64, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R8
        run_frame(12, 60, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); // R1 R8
        run_frame(60, 74, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); // R1
        run_frame(8, 20, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);  // R5 runt with errors
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule